// File: doc/BRIEF.md
# Three-wire serial EEPROM device

This block is the device-side logic of a small serial EEPROM. The host uses four pins: a chip select, a serial clock, a data input and a data output. The block takes in an instruction one bit at a time on rising serial-clock edges. It decodes the instruction and then acts on a behavioural byte array. It can stream data out, program one location, erase one location, fill the whole array with a pattern, or erase the whole array. A write-enable latch guards every programming operation. Each programming operation starts a self-timed busy period, counted in cycles of the system clock. During that period the data output reports ready or busy.

All pins are sampled with the free-running system clock. A serial-clock edge therefore counts only when the serial clock is slower than the system clock. A strap input selects the word size. It is either byte words with a 9-bit address, or 16-bit words with an 8-bit address. In 16-bit mode, word w occupies bytes 2w (upper half) and 2w+1 (lower half) of the same array.

Top module: `serial_eeprom_dev`

## Requirements
- R1: After reset the data output is released (doutEn low), programming is disabled, and every array bit reads as 1.
- R2: Only serial-clock rises that occur while cs is high sample di. While the block waits for an instruction, 0 bits are skipped, and the first 1 bit is taken as the start bit.
- R3: After the start bit comes a 2-bit opcode: 10 reads, 01 writes, 11 erases one location. Opcode 00 is decoded by the two most significant address bits: 11 enables programming, 00 disables it, 10 erases everything, and 01 writes the data to every location.
- R4: With org16 low the address field is 9 bits and the data field 8 bits. With org16 high they are 8 and 16 bits. Both fields are sent MSB first.
- R5: A read first drives a single 0 after the last address bit. Each later serial-clock rise then drives the next data bit, MSB first.
- R6: Once a word has been sent, the read continues with the next address, without another dummy bit. After the top address it continues from 0, and this lasts until cs falls.
- R7: WRITE, ERASE, WRALL and ERAL change nothing and start no busy period while programming is disabled.
- R8: A complete, enabled programming instruction takes effect when cs falls. WRITE and WRALL store the data. ERASE and ERAL store all ones.
- R9: After a programming operation starts, raising cs drives dout low while the operation is still in progress and high once it has finished. The operation lasts PROG_CYCLES system clocks.
- R10: A serial-clock rise with cs and di both high clears the ready/busy report and releases dout. If the block is not busy, that same rise also counts as the start bit of a new instruction.
- R11: Any bits beyond an instruction's length are ignored. Extra bits cancel WRITE, ERASE, WRALL and ERAL, but they do not undo READ, WEN or WDS.
- R12: Instructions sent while a programming operation is in progress have no effect.
- R13: doutEn is low whenever cs is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| org16 | input | 1 | Word size strap: 1 selects 16-bit words, 0 selects bytes |
| dout | output | 1 | Serial data out: read data or the ready/busy flag |
| doutEn | output | 1 | Output enable for dout; low means high impedance |

## Verification
The assertions assume that cs, sk and di come from the system clock domain and change far more slowly than it. This ensures that each serial-clock rise is seen exactly once, and that decode finishes before the next rise. They also assume that cs does not fall during the single decode cycle after the last address bit, and that org16 changes only while cs is low. The bench drives every pin on the falling system-clock edge. It holds each serial-clock phase for four system clocks and changes the strap only between instructions.

// File: rtl/serial_eeprom_pkg.sv
package serial_eeprom_pkg;

  typedef enum logic [1:0] {
    PG_WRITE = 2'd0,
    PG_ERASE = 2'd1,
    PG_WRALL = 2'd2,
    PG_ERAL  = 2'd3
  } prog_op_e;

  typedef struct packed {
    logic     clrShift;
    logic     shiftIn;
    logic     latchAddr;
    logic     loadWord;
    logic     shiftOut;
    logic     progStart;
    prog_op_e progOp;
  } dp_strobe_t;

endpackage

// File: rtl/serial_eeprom_dp.sv
module serial_eeprom_dp
  import serial_eeprom_pkg::*;
#(
  parameter int WORD_ADDR_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       org16,
  input  logic       di,
  input  dp_strobe_t st,
  output logic [1:0] opField,
  output logic [1:0] subField,
  output logic       doBit
);
  localparam int BA    = WORD_ADDR_W + 1;
  localparam int SH_W  = (BA + 2 > 16) ? BA + 2 : 16;
  localparam int DEPTH = 1 << BA;

  logic [SH_W-1:0] shiftReg;
  logic [BA-1:0]   addrReg, shiftAddr, nextAddr;
  logic [15:0]     outReg, firstWord, nextWord;
  logic [4:0]      outCnt, wordLen;
  logic [7:0]      mem [DEPTH];

  assign wordLen   = org16 ? 5'd16 : 5'd8;
  assign opField   = org16 ? shiftReg[WORD_ADDR_W+1:WORD_ADDR_W] : shiftReg[BA+1:BA];
  assign subField  = org16 ? shiftReg[WORD_ADDR_W-1:WORD_ADDR_W-2] : shiftReg[BA-1:BA-2];
  assign shiftAddr = org16 ? {1'b0, shiftReg[WORD_ADDR_W-1:0]} : shiftReg[BA-1:0];
  assign nextAddr  = org16 ? {1'b0, addrReg[WORD_ADDR_W-1:0] + WORD_ADDR_W'(1)}
                           : addrReg + BA'(1);

  always_comb begin
    if (org16) begin
      firstWord = {mem[{shiftAddr[WORD_ADDR_W-1:0], 1'b0}], mem[{shiftAddr[WORD_ADDR_W-1:0], 1'b1}]};
      nextWord  = {mem[{nextAddr[WORD_ADDR_W-1:0], 1'b0}], mem[{nextAddr[WORD_ADDR_W-1:0], 1'b1}]};
    end else begin
      firstWord = {mem[shiftAddr], 8'h00};
      nextWord  = {mem[nextAddr], 8'h00};
    end
  end

  // Instruction shifter and read-out path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      addrReg  <= '0;
      outReg   <= '0;
      outCnt   <= '0;
      doBit    <= 1'b0;
    end else begin
      if (st.clrShift) shiftReg <= '0;
      else if (st.shiftIn) shiftReg <= {shiftReg[SH_W-2:0], di};
      if (st.latchAddr) addrReg <= shiftAddr;
      if (st.loadWord) begin
        outReg <= firstWord;
        outCnt <= wordLen;
        doBit  <= 1'b0;
      end else if (st.shiftOut) begin
        doBit <= outReg[15];
        if (outCnt == 5'd1) begin
          addrReg <= nextAddr;
          outReg  <= nextWord;
          outCnt  <= wordLen;
        end else begin
          outReg <= {outReg[14:0], 1'b0};
          outCnt <= outCnt - 5'd1;
        end
      end
    end
  end

  // Behavioural storage array
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (st.progStart) begin
      case (st.progOp)
        PG_WRITE, PG_ERASE: begin
          if (org16) begin
            mem[{addrReg[WORD_ADDR_W-1:0], 1'b0}] <= (st.progOp == PG_ERASE) ? 8'hFF : shiftReg[15:8];
            mem[{addrReg[WORD_ADDR_W-1:0], 1'b1}] <= (st.progOp == PG_ERASE) ? 8'hFF : shiftReg[7:0];
          end else begin
            mem[addrReg] <= (st.progOp == PG_ERASE) ? 8'hFF : shiftReg[7:0];
          end
        end
        PG_WRALL: for (int i = 0; i < DEPTH; i++)
          mem[i] <= (org16 && (i % 2 == 0)) ? shiftReg[15:8] : shiftReg[7:0];
        default: for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      endcase
    end
  end

  // R5
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.loadWord |=> !doBit);
  // R6
  outcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.shiftOut |-> (outCnt != 5'd0 && outCnt <= 5'd16));
endmodule

// File: rtl/serial_eeprom_ctl.sv
module serial_eeprom_ctl
  import serial_eeprom_pkg::*;
#(
  parameter int WORD_ADDR_W = 8,
  parameter int PROG_CYCLES = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       sk,
  input  logic       di,
  input  logic       org16,
  input  logic [1:0] opField,
  input  logic [1:0] subField,
  input  logic       dpBit,
  output dp_strobe_t st,
  output logic       dout,
  output logic       doutEn
);
  localparam int BA    = WORD_ADDR_W + 1;
  localparam int TMR_W = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_TAIL, S_READ} state_e;

  state_e     state;
  prog_op_e   progOpReg;
  logic       skPrev, csPrev, skRise, csFall;
  logic       wenLatch, progOk, busy, statusPending;
  logic [5:0] bitCnt, aLen, fLen;
  logic [TMR_W-1:0] timer;

  assign skRise = cs & sk & ~skPrev;
  assign csFall = csPrev & ~cs;
  assign aLen   = org16 ? 6'(2 + WORD_ADDR_W) : 6'(2 + BA);
  assign fLen   = aLen + (org16 ? 6'd16 : 6'd8);

  always_comb begin
    st = '0;
    st.progOp = progOpReg;
    if (cs) begin
      case (state)
        S_IDLE: st.clrShift = skRise & di & ~busy;
        S_CMD: begin
          st.shiftIn = skRise & (bitCnt != aLen);
          if (bitCnt == aLen) begin
            st.latchAddr = 1'b1;
            st.loadWord  = (opField == 2'b10);
          end
        end
        S_DATA:  st.shiftIn  = skRise & (bitCnt != fLen);
        S_READ:  st.shiftOut = skRise;
        default: ;
      endcase
    end else begin
      st.progStart = csFall && (state == S_TAIL) && progOk && wenLatch && !busy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; progOpReg <= PG_WRITE;
      skPrev <= 1'b0; csPrev <= 1'b0;
      wenLatch <= 1'b0; progOk <= 1'b0; busy <= 1'b0; statusPending <= 1'b0;
      bitCnt <= '0; timer <= '0;
    end else begin
      skPrev <= sk;
      csPrev <= cs;
      if (busy) begin
        timer <= timer - TMR_W'(1);
        if (timer == TMR_W'(1)) busy <= 1'b0;
      end
      if (!cs) begin
        state <= S_IDLE;
        if (st.progStart) begin
          busy <= 1'b1; timer <= TMR_W'(PROG_CYCLES); statusPending <= 1'b1;
        end
      end else begin
        case (state)
          S_IDLE: if (skRise && di) begin
            statusPending <= 1'b0;
            if (!busy) begin state <= S_CMD; bitCnt <= '0; progOk <= 1'b0; end
          end
          S_CMD: if (bitCnt == aLen) begin
            case (opField)
              2'b10: state <= S_READ;
              2'b01: begin state <= S_DATA; progOpReg <= PG_WRITE; end
              2'b11: begin state <= S_TAIL; progOk <= 1'b1; progOpReg <= PG_ERASE; end
              default: case (subField)
                2'b11: begin state <= S_TAIL; wenLatch <= 1'b1; end
                2'b00: begin state <= S_TAIL; wenLatch <= 1'b0; end
                2'b10: begin state <= S_TAIL; progOk <= 1'b1; progOpReg <= PG_ERAL; end
                default: begin state <= S_DATA; progOpReg <= PG_WRALL; end
              endcase
            endcase
          end else if (skRise) bitCnt <= bitCnt + 6'd1;
          S_DATA: if (bitCnt == fLen) begin
            state <= S_TAIL; progOk <= 1'b1;
          end else if (skRise) bitCnt <= bitCnt + 6'd1;
          S_TAIL: if (skRise) progOk <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign doutEn = cs & ((state == S_READ) | ((state == S_IDLE) & statusPending));
  assign dout   = (state == S_READ) ? dpBit : ~busy;

  // R7
  wen_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wenLatch) |-> $past(state == S_CMD));
  // R8
  prog_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!cs && $past(wenLatch) && $past(state == S_TAIL)));
  // R9
  timer_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (timer != '0));
  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && busy && state == S_IDLE) |=> (state == S_IDLE));
endmodule

// File: rtl/serial_eeprom_dev.sv
module serial_eeprom_dev
  import serial_eeprom_pkg::*;
#(
  parameter int WORD_ADDR_W = 8,
  parameter int PROG_CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org16,
  output logic dout,
  output logic doutEn
);
  dp_strobe_t strobes;
  logic [1:0] opField, subField;
  logic       doBit;

  serial_eeprom_ctl #(.WORD_ADDR_W(WORD_ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org16(org16),
    .opField(opField), .subField(subField), .dpBit(doBit),
    .st(strobes), .dout(dout), .doutEn(doutEn)
  );

  serial_eeprom_dp #(.WORD_ADDR_W(WORD_ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .org16(org16), .di(di), .st(strobes),
    .opField(opField), .subField(subField), .doBit(doBit)
  );

  // R13
  float_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs)) |=> !doutEn);
endmodule

// File: tb/tb_serial_eeprom_dev.sv
module tb_serial_eeprom_dev;
  localparam int PROG = 300;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org16 = 1'b0;
  logic dout, doutEn;
  logic smpDo, smpEn;
  int   errors = 0, checks = 0;

  always #10 clk = ~clk;

  serial_eeprom_dev #(.WORD_ADDR_W(8), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org16(org16),
    .dout(dout), .doutEn(doutEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitClk(input logic b);
    di = b; tick(4);
    smpDo = dout; smpEn = doutEn;
    sk = 1'b1; tick(4);
    sk = 1'b0;
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bitClk(v[i]);
  endtask

  task automatic csUp();   cs = 1'b1; tick(4); endtask
  task automatic csDown(); cs = 1'b0; di = 1'b0; tick(4); endtask

  function automatic int aw(); return org16 ? 8 : 9; endfunction
  function automatic int dw(); return org16 ? 16 : 8; endfunction

  task automatic instr(input logic [1:0] op, input logic [8:0] addr,
                       input logic [15:0] data, input logic withData, input int extra);
    csUp(); bitClk(1'b1); sendBits(32'(op), 2); sendBits(32'(addr), aw());
    if (withData) sendBits(32'(data), dw());
    for (int i = 0; i < extra; i++) bitClk(1'b1);
    csDown();
  endtask

  task automatic ext(input logic [1:0] sub, input logic [15:0] data, input logic withData, input int extra);
    instr(2'b00, 9'(sub) << (aw() - 2), data, withData, extra);
  endtask

  // R9, R10: busy then ready then clear
  task automatic waitReady(input string req, input logic timeIt);
    int n = 0;
    csUp();
    check({req, " R9 busy"}, {30'd0, doutEn, dout}, 32'h2);
    while (dout !== 1'b1 && n < 2000) begin tick(1); n++; end
    check({req, " R9 ready"}, {30'd0, doutEn, dout}, 32'h3);
    if (timeIt) check("R9 duration window", 32'((n > PROG - 30) && (n < PROG)), 32'd1);
    bitClk(1'b1);
    csDown();
    csUp();
    check({req, " R10 status cleared"}, 32'(doutEn), 32'd0);
    csDown();
  endtask

  task automatic noProgram(input string req);
    csUp();
    check({req, " no busy report"}, 32'(doutEn), 32'd0);
    csDown();
  endtask

  task automatic readCheck(input string req, input logic [8:0] addr, input int nWords,
                           input logic [15:0] e0, input logic [15:0] e1, input int lead);
    logic [15:0] w;
    csUp();
    for (int i = 0; i < lead; i++) bitClk(1'b0);
    bitClk(1'b1); sendBits(32'b10, 2); sendBits(32'(addr), aw());
    bitClk(1'b0);
    check({req, " R5 dummy zero"}, {30'd0, smpEn, smpDo}, 32'h2);
    for (int k = 0; k < nWords; k++) begin
      w = '0;
      for (int b = 0; b < dw(); b++) begin bitClk(1'b0); w = {w[14:0], smpDo}; end
      check({req, (k == 0) ? " word0" : " word1"}, 32'(w), 32'((k == 0) ? e0 : e1));
    end
    csDown();
    check("R13 released after cs low", 32'(doutEn), 32'd0);
  endtask

  task automatic testReset();
    check("R1 R13 dout released at reset", 32'(doutEn), 32'd0);
    readCheck("R1 erased at reset", 9'd0, 1, 16'h00FF, 16'h0, 0);
  endtask

  task automatic testDisabled();
    instr(2'b01, 9'd5, 16'h00A5, 1'b1, 0);
    noProgram("R7 write while disabled");
    readCheck("R7 location unchanged", 9'd5, 1, 16'h00FF, 16'h0, 0);
  endtask

  task automatic testWriteRead();
    ext(2'b11, 16'h0, 1'b0, 0);
    instr(2'b01, 9'd5, 16'h00A5, 1'b1, 0);
    waitReady("R8 write x8", 1'b1);
    readCheck("R2 R5 leading zeros then read", 9'd5, 1, 16'h00A5, 16'h0, 3);
  endtask

  task automatic testStream();
    instr(2'b01, 9'd6, 16'h003C, 1'b1, 0);
    waitReady("R8 write addr6", 1'b0);
    readCheck("R6 auto increment", 9'd5, 2, 16'h00A5, 16'h003C, 0);
    instr(2'b01, 9'd511, 16'h005A, 1'b1, 0);
    waitReady("R8 write top", 1'b0);
    readCheck("R6 wrap to zero", 9'd511, 2, 16'h005A, 16'h00FF, 0);
  endtask

  task automatic testErase();
    instr(2'b11, 9'd5, 16'h0, 1'b0, 0);
    waitReady("R8 erase", 1'b0);
    readCheck("R3 R8 erase sets ones", 9'd5, 1, 16'h00FF, 16'h0, 0);
  endtask

  task automatic testMalformed();
    instr(2'b01, 9'd7, 16'h0011, 1'b1, 1);
    noProgram("R11 long write cancelled");
    readCheck("R11 long write left data", 9'd7, 1, 16'h00FF, 16'h0, 0);
    ext(2'b00, 16'h0, 1'b0, 0);
    instr(2'b01, 9'd6, 16'h0000, 1'b1, 0);
    noProgram("R7 write after disable");
    readCheck("R7 disabled write ignored", 9'd6, 1, 16'h003C, 16'h0, 0);
    ext(2'b11, 16'h0, 1'b0, 2);
    instr(2'b01, 9'd8, 16'h0099, 1'b1, 0);
    waitReady("R11 enable with extra bits", 1'b0);
    readCheck("R11 enable still effective", 9'd8, 1, 16'h0099, 16'h0, 0);
  endtask

  task automatic testBusyIgnore();
    instr(2'b01, 9'd10, 16'h0077, 1'b1, 0);
    csUp();
    check("R9 busy shown", {30'd0, doutEn, dout}, 32'h2);
    bitClk(1'b1);
    tick(2);
    check("R10 clear while busy", 32'(doutEn), 32'd0);
    sendBits(32'b00, 2); sendBits(32'h100, 9);
    csDown();
    tick(PROG + 20);
    csUp();
    check("R10 status stays cleared", 32'(doutEn), 32'd0);
    csDown();
    readCheck("R12 write landed", 9'd10, 1, 16'h0077, 16'h0, 0);
    readCheck("R12 erase-all ignored", 9'd6, 1, 16'h003C, 16'h0, 0);
  endtask

  task automatic testWide();
    org16 = 1'b1; tick(2);
    ext(2'b01, 16'h1234, 1'b1, 0);
    waitReady("R3 R8 write-all x16", 1'b0);
    readCheck("R4 x16 word0", 9'd0, 1, 16'h1234, 16'h0, 0);
    readCheck("R6 x16 wrap", 9'd255, 2, 16'h1234, 16'h1234, 0);
    ext(2'b10, 16'h0, 1'b0, 0);
    waitReady("R3 R8 erase-all x16", 1'b0);
    instr(2'b01, 9'd2, 16'hBEEF, 1'b1, 0);
    waitReady("R4 write x16", 1'b0);
    readCheck("R4 R8 x16 stream", 9'd1, 2, 16'hFFFF, 16'hBEEF, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    testReset();
    testDisabled();
    testWriteRead();
    testStream();
    testErase();
    testMalformed();
    testBusyIgnore();
    testWide();
    check("R13 idle with cs low", 32'(doutEn), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule